// File: doc/BRIEF.md
# Power-Fail Interrupt Monitor

This block sits between an asynchronous power-fail line from the supply and the CPU's interrupt logic. It brings the line into the clock domain through a flop chain and shows its present level to the CPU. When the synchronised line goes from low to high, it latches a request that is presented with device code 0. That request beats every other source, does not look at the interrupt mask, and stays latched until the CPU takes it.

A separate power-down-mode enable removes the power-fail request. While the enable is high, a pending request is dropped and new rising edges do not latch one. Lower-priority devices drive a request vector. The CPU masks that vector bit by bit. When no power-fail request is active, the block offers the lowest-numbered unmasked device. Device `i` is reported as code `i+1`.

The offered interrupt is a valid/ready stream. `int_valid` says a request is on offer and `grant_code` names it. The CPU raises `int_ready` to take it, and the transfer happens in any cycle where both are high. The offer is not held still under back-pressure. If a power-fail request arrives while `int_ready` is low, `grant_code` switches to 0 at once, so the CPU must read the code in the cycle it accepts. Taking a power-fail grant clears the latched request. Taking a device grant changes nothing here, because the device drops its own request line.

Top module: `pwrfail_intr_mon`

## Requirements
- R1: `pf_state` equals the level `pf_raw` had before the second rising clock edge back. It lags the input by two edges.
- R2: A low-to-high change of the synchronised line, with `pd_mode_en` low, latches a power-fail request. The request is offered as `int_valid`=1 with `grant_code`=0 three edges after `pf_raw` rises. A line that stays high does not latch a second request after the first is taken.
- R3: While a power-fail request is active, `grant_code` is 0 whatever lower-priority requests are present.
- R4: A power-fail request is offered with `int_valid`=1 even when every bit of `irq_mask` is set.
- R5: While `pd_mode_en` is 1, no power-fail request is offered. A rising edge seen in such a cycle latches nothing. A request already pending is cleared and does not return when the enable goes low.
- R6: A latched power-fail request stays offered until a cycle with `int_valid`, `int_ready` and `grant_code`=0 all high. This holds even if `pf_raw` has fallen first. A rising edge in the accepting cycle latches a new request.
- R7: With no active power-fail request, `grant_code` is `i+1` for the lowest index `i` where `dev_req[i]`=1 and `irq_mask[i]`=0. A mask bit of 1 blocks that device.
- R8: With no active power-fail request and no unmasked device request, `int_valid` is 0 and `grant_code` is 0.
- R9: During and right after reset, no request is latched and `pf_state` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pf_raw | input | 1 | Asynchronous power-fail line from the supply |
| pd_mode_en | input | 1 | Power-down mode enable; blocks and clears the power-fail request |
| dev_req | input | NUM_SRC | Lower-priority device requests, bit i is device i |
| irq_mask | input | NUM_SRC | CPU mask, 1 blocks device i |
| int_ready | input | 1 | CPU accepts the offered interrupt |
| pf_state | output | 1 | Synchronised power-fail level for the CPU to read |
| int_valid | output | 1 | An interrupt is on offer |
| grant_code | output | CODE_W | Device code on offer, 0 for power fail |

## Verification
The power-fail line is tried in several ways:
- short pulses that fall before the CPU accepts, which separates a latched request from a level-following one;
- a held-high line after acceptance, which shows edge detection rather than level detection;
- edges that arrive while power-down mode is on, and pending requests that power-down mode clears.

Device patterns cover all masked, all unmasked and scattered bits. They show that power fail wins and ignores the mask, and that the lowest unmasked index wins among devices.

A random mix of all inputs, with `int_ready` dropped often, is compared each cycle against a bench model. This catches off-by-one latency and back-pressure mistakes.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
  localparam int DEF_NUM_SRC  = 8;
  localparam int DEF_CODE_W   = 6;
  localparam int DEF_SYNC_LEN = 2;

  typedef enum logic {
    SEL_DEVICE  = 1'b0,
    SEL_PWRFAIL = 1'b1
  } grant_sel_e;
endpackage

// File: rtl/pfm_sync.sv
module pfm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pfm_latch.sv
module pfm_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic line_sync,
  input  logic block_en,
  input  logic taken,
  output logic pending
);
  logic line_d;
  logic edge_up;

  assign edge_up = line_sync & ~line_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_d  <= 1'b0;
      pending <= 1'b0;
    end else begin
      line_d <= line_sync;
      if (block_en)      pending <= 1'b0;
      else if (edge_up)  pending <= 1'b1;
      else if (taken)    pending <= 1'b0;
    end
  end
endmodule

// File: rtl/pfm_lowpri_arb.sv
module pfm_lowpri_arb #(
  parameter int NUM_SRC = 8,
  parameter int CODE_W  = 6
) (
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] mask,
  output logic               any,
  output logic [CODE_W-1:0]  code
);
  logic [NUM_SRC-1:0] eligible;

  assign eligible = req & ~mask;
  assign any      = |eligible;

  always_comb begin
    code = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i]) code = CODE_W'(i + 1);
    end
  end
endmodule

// File: rtl/pwrfail_intr_mon.sv
module pwrfail_intr_mon #(
  parameter int NUM_SRC  = pfm_pkg::DEF_NUM_SRC,
  parameter int CODE_W   = pfm_pkg::DEF_CODE_W,
  parameter int SYNC_LEN = pfm_pkg::DEF_SYNC_LEN
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pf_raw,
  input  logic               pd_mode_en,
  input  logic [NUM_SRC-1:0] dev_req,
  input  logic [NUM_SRC-1:0] irq_mask,
  input  logic               int_ready,
  output logic               pf_state,
  output logic               int_valid,
  output logic [CODE_W-1:0]  grant_code
);
  import pfm_pkg::*;

  localparam logic [CODE_W-1:0] PF_CODE = '0;

  logic              pf_pend;
  logic              dev_any;
  logic [CODE_W-1:0] dev_code;
  logic              pf_taken;
  grant_sel_e        sel;

  pfm_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pf_raw),
    .q_sync  (pf_state)
  );

  pfm_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_sync (pf_state),
    .block_en  (pd_mode_en),
    .taken     (pf_taken),
    .pending   (pf_pend)
  );

  pfm_lowpri_arb #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W)) u_arb (
    .req  (dev_req),
    .mask (irq_mask),
    .any  (dev_any),
    .code (dev_code)
  );

  assign sel        = (pf_pend && !pd_mode_en) ? SEL_PWRFAIL : SEL_DEVICE;
  assign int_valid  = (sel == SEL_PWRFAIL) || dev_any;
  assign grant_code = (sel == SEL_PWRFAIL) ? PF_CODE : dev_code;
  assign pf_taken   = (sel == SEL_PWRFAIL) && int_ready;
endmodule

// File: rtl/pwrfail_intr_mon_chk.sv
module pwrfail_intr_mon_chk #(
  parameter int NUM_SRC = 8,
  parameter int CODE_W  = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pd_mode_en,
  input logic [NUM_SRC-1:0] dev_req,
  input logic [NUM_SRC-1:0] irq_mask,
  input logic               int_ready,
  input logic               pf_state,
  input logic               int_valid,
  input logic [CODE_W-1:0]  grant_code,
  input logic               pf_pend
);
  // R3 and R4: an active power-fail request is offered with code 0
  a_r3_pf_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_pend && !pd_mode_en) |-> (int_valid && grant_code == '0));

  // R2: a synchronised rising edge outside power-down mode latches a request
  a_r2_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pf_state) && !pd_mode_en) |=> pf_pend);

  // R5: power-down mode leaves nothing pending
  a_r5_pd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pd_mode_en |=> !pf_pend);

  // R6: a request is held until it is accepted
  a_r6_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_pend && !pd_mode_en && !int_ready) |=> pf_pend);

  // R7: without a power-fail request, a valid grant names a device
  a_r7_dev_code: assert property (@(posedge clk) disable iff (!rst_n)
    (!(pf_pend && !pd_mode_en) && int_valid) |-> (grant_code != '0));

  // R8: no source means no offer
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!(pf_pend && !pd_mode_en) && ((dev_req & ~irq_mask) == '0)) |-> !int_valid);
endmodule

bind pwrfail_intr_mon pwrfail_intr_mon_chk #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pd_mode_en (pd_mode_en),
  .dev_req    (dev_req),
  .irq_mask   (irq_mask),
  .int_ready  (int_ready),
  .pf_state   (pf_state),
  .int_valid  (int_valid),
  .grant_code (grant_code),
  .pf_pend    (pf_pend)
);

// File: tb/pwrfail_intr_mon_test.sv
`timescale 1ns/1ps
module pwrfail_intr_mon_test;
  localparam int N  = 8;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pf_raw = 1'b0;
  logic          pd_mode_en = 1'b0;
  logic [N-1:0]  dev_req = '0;
  logic [N-1:0]  irq_mask = '0;
  logic          int_ready = 1'b0;
  logic          pf_state;
  logic          int_valid;
  logic [CW-1:0] grant_code;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  // bench model state
  bit m_h1, m_h2, m_hp, m_pend;

  always #4 clk = ~clk;

  pwrfail_intr_mon #(.NUM_SRC(N), .CODE_W(CW), .SYNC_LEN(2)) uut (
    .clk(clk), .rst_n(rst_n), .pf_raw(pf_raw), .pd_mode_en(pd_mode_en),
    .dev_req(dev_req), .irq_mask(irq_mask), .int_ready(int_ready),
    .pf_state(pf_state), .int_valid(int_valid), .grant_code(grant_code)
  );

  function automatic bit exp_pfsel();
    return m_pend && !pd_mode_en;
  endfunction

  function automatic bit exp_valid();
    return exp_pfsel() || ((dev_req & ~irq_mask) != '0);
  endfunction

  function automatic logic [CW-1:0] exp_code();
    logic [N-1:0] e;
    e = dev_req & ~irq_mask;
    if (exp_pfsel()) return '0;
    for (int i = 0; i < N; i++) if (e[i]) return CW'(i + 1);
    return '0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all();
    string t;
    if (pd_mode_en && m_pend) t = "R5";
    else if (exp_pfsel()) t = (irq_mask != '0) ? "R4" : "R3";
    else if (exp_valid()) t = "R7";
    else t = "R8";
    check("R1 pf_state", pf_state, m_h2);
    check({t, " int_valid"}, int_valid, exp_valid());
    check({t, " grant_code"}, grant_code, exp_code());
  endtask

  // drive inputs, check, then clock the model along with the design
  task automatic step(input bit raw, input bit pd, input logic [N-1:0] rq,
                      input logic [N-1:0] mk, input bit rdy);
    bit take, rise;
    pf_raw = raw; pd_mode_en = pd; dev_req = rq; irq_mask = mk; int_ready = rdy;
    #1;
    check_all();
    take = exp_pfsel() && rdy;
    rise = m_h2 && !m_hp;
    @(posedge clk);
    if (pd) m_pend = 1'b0;
    else if (rise) m_pend = 1'b1;
    else if (take) m_pend = 1'b0;
    m_hp = m_h2; m_h2 = m_h1; m_h1 = raw;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_h1 = 0; m_h2 = 0; m_hp = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    dev_req = '0; #1;
    check("R9 reset pf_state", pf_state, 0);
    check("R9 reset int_valid", int_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: latency of three edges, with devices masked off (R4)
    step(1, 0, 8'hFF, 8'hFF, 0);
    step(1, 0, 8'hFF, 8'hFF, 0);
    check("R2 not yet at edge 2", int_valid, 0);
    step(1, 0, 8'hFF, 8'hFF, 0);
    check("R2 offered at edge 3", int_valid, 1);
    check("R2 code 0", grant_code, 0);
    // R6: line falls, request held while not ready
    step(0, 0, 8'h0C, 8'h00, 0);
    step(0, 0, 8'h0C, 8'h00, 0);
    check("R6 held after fall", grant_code, 0);
    step(0, 0, 8'h0C, 8'h00, 1);
    check("R7 device after take", grant_code, 3);
    // R2: held-high line does not re-raise after acceptance
    step(1, 0, 8'h00, 8'h00, 0);
    repeat (3) step(1, 0, 8'h00, 8'h00, 1);
    repeat (3) step(1, 0, 8'h00, 8'h00, 0);
    check("R2 no second request", int_valid, 0);
    step(0, 0, 8'h00, 8'h00, 0);
    repeat (3) step(0, 0, 8'h00, 8'h00, 0);
    // R5: edge during power-down latches nothing
    repeat (4) step(1, 1, 8'h00, 8'h00, 0);
    repeat (2) step(1, 0, 8'h00, 8'h00, 0);
    check("R5 edge blocked", int_valid, 0);
    repeat (3) step(0, 0, 8'h00, 8'h00, 0);
    // R5: pending request cleared by power-down mode
    repeat (4) step(1, 0, 8'h80, 8'h00, 0);
    check("R3 pf beats device", grant_code, 0);
    step(1, 1, 8'h80, 8'h00, 0);
    step(1, 0, 8'h80, 8'h00, 0);
    check("R5 cleared stays cleared", grant_code, 8);
    repeat (3) step(0, 0, 8'h00, 8'h00, 0);
    // R7: lowest unmasked index wins
    step(0, 0, 8'b1011_0110, 8'b0000_0110, 0);
    check("R7 lowest unmasked", grant_code, 5);

    // random mix
    for (int k = 0; k < 600; k++) begin
      bit raw;
      raw = ($urandom % 6 == 0) ? ~pf_raw : pf_raw;
      step(raw, ($urandom % 12 == 0), N'($urandom), N'($urandom & $urandom),
           ($urandom % 3 == 0));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule